// File: doc/BRIEF.md
# UART Interrupt Mask and Status Unit

This block is the interrupt controller of a serial port. It watches thirteen raw event lines from the receive path, the transmit path and the receive timeout. It records each rising edge in a sticky status register. It combines the status with a mask and drives one interrupt line toward the processor.

The mask is never written directly. Software sets mask bits through a write-only enable register and clears them through a write-only disable register. Status bits are cleared by writing ones to them. A separate channel view shows the live, unmasked level of the four FIFO conditions that software polls.

All registers share one bit layout:

| Bit | Event |
|-----|-------|
| 0 | receive threshold reached |
| 1 | receive queue empty |
| 2 | receive queue full |
| 3 | transmit queue empty |
| 4 | transmit queue full |
| 5 | overrun |
| 6 | framing error |
| 7 | parity error |
| 8 | receive timeout |
| 9 to 12 | spare event inputs |

Top module: `uart_irq_ctrl`

## Requirements
- R1: After reset the mask and the status both read 0x0000, and `irq` is low.
- R2: A write to offset 0x08 (enable) sets every mask bit whose data bit is 1 and leaves the other mask bits unchanged. The mask reads back at offset 0x10.
- R3: A write to offset 0x0C (disable) clears every mask bit whose data bit is 1 and leaves the other mask bits unchanged.
- R4: Offsets 0x08 and 0x0C always read 0. The mask at offset 0x10 is read-only, so a write there leaves the mask unchanged.
- R5: A 0-to-1 transition on `evt_raw[k]` sets status bit k (read at offset 0x14) one clock later, whether or not mask bit k is set. An input held high does not set the bit again after it has been cleared.
- R6: A write to offset 0x14 clears each status bit whose data bit is 1. Status bits whose data bit is 0 are unchanged.
- R7: When a rising event and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R8: `irq` is high exactly when some bit is set in both the status and the mask.
- R9: Offset 0x2C shows the live levels of `evt_raw` bits 0, 1, 3 and 4, and 0 in every other bit position. Writes to offset 0x2C have no effect.
- R10: Data bits 13 and above are ignored on writes and read as 0. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe for one cycle |
| reg_addr | input | 8 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| evt_raw | input | 13 | Raw event levels, laid out as in the table above |
| irq | output | 1 | Interrupt request |

## Verification
The riskiest corner is an event that rises in the same cycle as a clearing write to the same bit. A design that lets the clear win would lose that event, and the status bit would read 0. A second corner is an event held high across a clear. A level-sensitive design would set the bit again at once and leave the interrupt stuck.

Other tests cover the following:
- Enable and disable writes are partial. A design that loads the mask with the data would disturb neighbouring mask bits.
- Writes to the mask offset, the channel view and the upper data bits must all be ignored. A mis-decoded address would corrupt the mask.
- Masked events must still be recorded. Enabling the mask afterwards must raise `irq` without a new event.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
   // Bit positions shared by enable, disable, mask, status and channel view.
   localparam int BIT_RX_TRIG = 0;
   localparam int BIT_RX_EMPTY = 1;
   localparam int BIT_RX_FULL = 2;
   localparam int BIT_TX_EMPTY = 3;
   localparam int BIT_TX_FULL = 4;
   localparam int BIT_OVERRUN = 5;
   localparam int BIT_FRAMING = 6;
   localparam int BIT_PARITY = 7;
   localparam int BIT_RX_TOUT = 8;
   localparam int NUM_NAMED = 9;
   localparam int EVT_W_DEF = 13;

   // Register offsets; the decoder compares against these.
   localparam logic [7:0] OFF_ENABLE = 8'h08;
   localparam logic [7:0] OFF_DISABLE = 8'h0C;
   localparam logic [7:0] OFF_MASK = 8'h10;
   localparam logic [7:0] OFF_STATUS = 8'h14;
   localparam logic [7:0] OFF_CHAN = 8'h2C;

   // True when bit position k appears in the unmasked channel view.
   function automatic bit chan_visible(input int k);
      return (k == BIT_RX_TRIG) || (k == BIT_RX_EMPTY) ||
             (k == BIT_TX_EMPTY) || (k == BIT_TX_FULL);
   endfunction
endpackage

// File: rtl/uirq_status_bank.sv
module uirq_status_bank #(
   parameter int EVT_W = 13,
   parameter bit LEVEL_SET = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [EVT_W-1:0] evt_raw,
   input  logic             clr_we,
   input  logic [EVT_W-1:0] clr_bits,
   output logic [EVT_W-1:0] status
);
   initial begin
      if (EVT_W < 1) $error("uirq_status_bank: EVT_W must be positive");
   end

   logic [EVT_W-1:0] set_pulse;

   for (genvar k = 0; k < EVT_W; k++) begin : g_bit
      if (LEVEL_SET) begin : g_level
         // Variant: status follows the input level (sets while high).
         assign set_pulse[k] = evt_raw[k];
      end else begin : g_edge
         // Variant: status sets only on a rising edge of the input.
         logic prev_q;

         always_ff @(posedge clk) begin
            if (!rst_n) prev_q <= 1'b0;
            else        prev_q <= evt_raw[k];
         end

         assign set_pulse[k] = evt_raw[k] & ~prev_q;
      end

      // Sticky bit: a new event takes priority over a clearing write.
      always_ff @(posedge clk) begin
         if (!rst_n)                      status[k] <= 1'b0;
         else if (set_pulse[k])           status[k] <= 1'b1;
         else if (clr_we && clr_bits[k])  status[k] <= 1'b0;
      end
   end
endmodule

// File: rtl/uirq_mask_bank.sv
module uirq_mask_bank #(
   parameter int EVT_W = 13
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             set_we,
   input  logic             clr_we,
   input  logic [EVT_W-1:0] bits,
   output logic [EVT_W-1:0] mask
);
   initial begin
      if (EVT_W < 1) $error("uirq_mask_bank: EVT_W must be positive");
   end

   for (genvar k = 0; k < EVT_W; k++) begin : g_bit
      always_ff @(posedge clk) begin
         if (!rst_n)                  mask[k] <= 1'b0;
         else if (set_we && bits[k])  mask[k] <= 1'b1;
         else if (clr_we && bits[k])  mask[k] <= 1'b0;
      end
   end
endmodule

// File: rtl/uirq_rd_mux.sv
module uirq_rd_mux #(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 8,
   parameter int EVT_W = 13,
   parameter logic [ADDR_W-1:0] OFF_MASK = 8'h10,
   parameter logic [ADDR_W-1:0] OFF_STATUS = 8'h14,
   parameter logic [ADDR_W-1:0] OFF_CHAN = 8'h2C
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [EVT_W-1:0]  mask,
   input  logic [EVT_W-1:0]  status,
   input  logic [EVT_W-1:0]  chan,
   output logic [DATA_W-1:0] rdata
);
   initial begin
      if (EVT_W >= DATA_W) $error("uirq_rd_mux: EVT_W must be below DATA_W");
   end

   logic [EVT_W-1:0] sel;

   always_comb begin
      sel = '0;
      if (addr == OFF_MASK)        sel = mask;
      else if (addr == OFF_STATUS) sel = status;
      else if (addr == OFF_CHAN)   sel = chan;
   end

   // Upper data bits are always zero.
   assign rdata = {{(DATA_W-EVT_W){1'b0}}, sel};
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl #(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 8,
   parameter int EVT_W = uirq_pkg::EVT_W_DEF,
   parameter bit LEVEL_SET = 1'b0,
   parameter logic [ADDR_W-1:0] OFF_EN = uirq_pkg::OFF_ENABLE,
   parameter logic [ADDR_W-1:0] OFF_DIS = uirq_pkg::OFF_DISABLE,
   parameter logic [ADDR_W-1:0] OFF_MSK = uirq_pkg::OFF_MASK,
   parameter logic [ADDR_W-1:0] OFF_ST = uirq_pkg::OFF_STATUS,
   parameter logic [ADDR_W-1:0] OFF_CH = uirq_pkg::OFF_CHAN
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic [EVT_W-1:0]  evt_raw,
   output logic              irq
);
   localparam int SPARE_W = DATA_W - EVT_W;

   initial begin
      if (EVT_W < uirq_pkg::NUM_NAMED)
         $error("uart_irq_ctrl: EVT_W too small for the named events");
      if (SPARE_W < 1)
         $error("uart_irq_ctrl: DATA_W must exceed EVT_W");
      if (OFF_EN[1:0] != 2'b00 || OFF_DIS[1:0] != 2'b00 ||
          OFF_MSK[1:0] != 2'b00 || OFF_ST[1:0] != 2'b00 ||
          OFF_CH[1:0] != 2'b00)
         $error("uart_irq_ctrl: offsets must be word aligned");
      if (OFF_EN == OFF_DIS || OFF_EN == OFF_MSK || OFF_EN == OFF_ST ||
          OFF_EN == OFF_CH || OFF_DIS == OFF_MSK || OFF_DIS == OFF_ST ||
          OFF_DIS == OFF_CH || OFF_MSK == OFF_ST || OFF_MSK == OFF_CH ||
          OFF_ST == OFF_CH)
         $error("uart_irq_ctrl: offsets must be distinct");
   end

   logic             wr_en_hit;
   logic             wr_dis_hit;
   logic             wr_st_hit;
   logic [EVT_W-1:0] wbits;
   logic [EVT_W-1:0] mask_q;
   logic [EVT_W-1:0] status_q;
   logic [EVT_W-1:0] chan_view;
   logic             unused_wdata_hi;

   // Address decode for writes.
   assign wr_en_hit  = reg_wr && (reg_addr == OFF_EN);
   assign wr_dis_hit = reg_wr && (reg_addr == OFF_DIS);
   assign wr_st_hit  = reg_wr && (reg_addr == OFF_ST);

   // Only the low EVT_W data bits matter; the rest are dropped.
   assign wbits           = reg_wdata[EVT_W-1:0];
   assign unused_wdata_hi = ^reg_wdata[DATA_W-1:EVT_W];

   uirq_mask_bank #(
      .EVT_W (EVT_W)
   ) u_mask (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_we (wr_en_hit),
      .clr_we (wr_dis_hit),
      .bits   (wbits),
      .mask   (mask_q)
   );

   uirq_status_bank #(
      .EVT_W     (EVT_W),
      .LEVEL_SET (LEVEL_SET)
   ) u_status (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt_raw  (evt_raw),
      .clr_we   (wr_st_hit),
      .clr_bits (wbits),
      .status   (status_q)
   );

   // Channel view: live levels of the FIFO conditions only.
   for (genvar k = 0; k < EVT_W; k++) begin : g_chan
      if (uirq_pkg::chan_visible(k)) begin : g_on
         assign chan_view[k] = evt_raw[k];
      end else begin : g_off
         assign chan_view[k] = 1'b0;
      end
   end

   uirq_rd_mux #(
      .DATA_W     (DATA_W),
      .ADDR_W     (ADDR_W),
      .EVT_W      (EVT_W),
      .OFF_MASK   (OFF_MSK),
      .OFF_STATUS (OFF_ST),
      .OFF_CHAN   (OFF_CH)
   ) u_rd (
      .addr   (reg_addr),
      .mask   (mask_q),
      .status (status_q),
      .chan   (chan_view),
      .rdata  (reg_rdata)
   );

   assign irq = |(status_q & mask_q);
endmodule

// File: rtl/uart_irq_ctrl_chk.sv
module uart_irq_ctrl_chk #(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 8,
   parameter int EVT_W = 13,
   parameter bit LEVEL_SET = 1'b0,
   parameter logic [ADDR_W-1:0] OFF_EN = 8'h08,
   parameter logic [ADDR_W-1:0] OFF_DIS = 8'h0C,
   parameter logic [ADDR_W-1:0] OFF_ST = 8'h14
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [DATA_W-1:0] reg_wdata,
   input logic [DATA_W-1:0] reg_rdata,
   input logic [EVT_W-1:0]  evt_raw,
   input logic [EVT_W-1:0]  mask_q,
   input logic [EVT_W-1:0]  status_q,
   input logic              irq
);
   logic [EVT_W-1:0] prev_c;
   logic [EVT_W-1:0] set_c;
   logic             en_w;
   logic             dis_w;
   logic             st_w;

   always_ff @(posedge clk) begin
      if (!rst_n) prev_c <= '0;
      else        prev_c <= evt_raw;
   end

   assign set_c = LEVEL_SET ? evt_raw : (evt_raw & ~prev_c);
   assign en_w  = reg_wr && (reg_addr == OFF_EN);
   assign dis_w = reg_wr && (reg_addr == OFF_DIS);
   assign st_w  = reg_wr && (reg_addr == OFF_ST);

   AST_EN_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      en_w |=> ((mask_q & $past(reg_wdata[EVT_W-1:0])) == $past(reg_wdata[EVT_W-1:0]))); // R2
   AST_DIS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      dis_w |=> ((mask_q & $past(reg_wdata[EVT_W-1:0])) == '0)); // R3
   AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(en_w || dis_w) |=> $stable(mask_q)); // R4
   AST_WO_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      ((reg_addr == OFF_EN) || (reg_addr == OFF_DIS)) |-> (reg_rdata == '0)); // R4
   AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (set_c != '0) |=> ((status_q & $past(set_c)) == $past(set_c))); // R5
   AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
      st_w |=> ((status_q & $past(reg_wdata[EVT_W-1:0] & ~set_c)) == '0)); // R6
   AST_NO_SPONTANEOUS: assert property (@(posedge clk) disable iff (!rst_n)
      (set_c == '0) |=> ((status_q & ~$past(status_q)) == '0)); // R7
   AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q == '0) |-> !irq); // R8
   AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rdata[DATA_W-1:EVT_W] == '0); // R10
endmodule

bind uart_irq_ctrl uart_irq_ctrl_chk #(
   .DATA_W    (DATA_W),
   .ADDR_W    (ADDR_W),
   .EVT_W     (EVT_W),
   .LEVEL_SET (LEVEL_SET),
   .OFF_EN    (OFF_EN),
   .OFF_DIS   (OFF_DIS),
   .OFF_ST    (OFF_ST)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_wr    (reg_wr),
   .reg_addr  (reg_addr),
   .reg_wdata (reg_wdata),
   .reg_rdata (reg_rdata),
   .evt_raw   (evt_raw),
   .mask_q    (mask_q),
   .status_q  (status_q),
   .irq       (irq)
);

// File: tb/uart_irq_ctrl_bench.sv
`timescale 1ns/1ps
module uart_irq_ctrl_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [7:0]  reg_addr = 8'h00;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [12:0] evt_raw = '0;
   logic        irq;
   int          checks = 0;
   int          errors = 0;

   localparam logic [7:0] A_EN = 8'h08, A_DIS = 8'h0C, A_MSK = 8'h10,
                          A_ST = 8'h14, A_CH = 8'h2C;

   always #4 clk = ~clk;

   uart_irq_ctrl u_uart_irq_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (reg_wr),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .evt_raw   (evt_raw),
      .irq       (irq)
   );

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got %h expected %h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0; reg_wdata = '0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic set_evt(input logic [12:0] v);
      @(negedge clk);
      evt_raw = v;
      @(negedge clk);
   endtask

   task automatic t_reset();
      logic [31:0] d;
      rd(A_MSK, d); check("R1 mask", d, 32'h0);
      rd(A_ST, d);  check("R1 status", d, 32'h0);
      check("R1 irq", {31'h0, irq}, 32'h0);
   endtask

   task automatic t_mask();
      logic [31:0] d;
      wr(A_EN, 32'h0A5);  rd(A_MSK, d); check("R2 enable", d, 32'h0A5);
      wr(A_EN, 32'h100);  rd(A_MSK, d); check("R2 partial set", d, 32'h1A5);
      wr(A_DIS, 32'h005); rd(A_MSK, d); check("R3 partial clear", d, 32'h1A0);
      rd(A_EN, d);  check("R4 enable reads 0", d, 32'h0);
      rd(A_DIS, d); check("R4 disable reads 0", d, 32'h0);
      wr(A_MSK, 32'h1FFF); rd(A_MSK, d); check("R4 mask read-only", d, 32'h1A0);
      wr(A_DIS, 32'h1FFF); rd(A_MSK, d); check("R3 clear all", d, 32'h0);
   endtask

   task automatic t_status();
      logic [31:0] d;
      set_evt(13'h020);
      rd(A_ST, d); check("R5 masked event recorded", d, 32'h020);
      check("R8 irq low while masked", {31'h0, irq}, 32'h0);
      wr(A_EN, 32'h020);
      #1 check("R8 irq after enabling", {31'h0, irq}, 32'h1);
      wr(A_ST, 32'h000); rd(A_ST, d); check("R6 zero write keeps", d, 32'h020);
      wr(A_ST, 32'h020); rd(A_ST, d); check("R6 clear", d, 32'h0);
      check("R8 irq low after clear", {31'h0, irq}, 32'h0);
      rd(A_ST, d); check("R5 held level no reset", d, 32'h0);
      set_evt(13'h000); set_evt(13'h020);
      rd(A_ST, d); check("R5 new edge sets", d, 32'h020);
      wr(A_DIS, 32'h020);
      #1 check("R8 irq low when unmasked bit off", {31'h0, irq}, 32'h0);
      wr(A_ST, 32'h1FFF); set_evt(13'h000);
   endtask

   task automatic t_race();
      logic [31:0] d;
      set_evt(13'h100); set_evt(13'h000);
      @(negedge clk);
      evt_raw = 13'h100; reg_wr = 1'b1; reg_addr = A_ST; reg_wdata = 32'h100;
      @(negedge clk);
      reg_wr = 1'b0; reg_wdata = '0;
      rd(A_ST, d); check("R7 event beats clear", d, 32'h100);
      wr(A_ST, 32'h100); set_evt(13'h000);
      rd(A_ST, d); check("R6 cleared after race", d, 32'h0);
   endtask

   task automatic t_chan();
      logic [31:0] d;
      @(negedge clk); evt_raw = 13'h1FFF;
      rd(A_CH, d); check("R9 only FIFO bits", d, 32'h01B);
      @(negedge clk); evt_raw = 13'h00A;
      rd(A_CH, d); check("R9 live level", d, 32'h00A);
      wr(A_CH, 32'hFFFF_FFFF); rd(A_MSK, d); check("R9 write ignored mask", d, 32'h0);
      rd(A_CH, d); check("R9 write ignored view", d, 32'h00A);
      set_evt(13'h000); wr(A_ST, 32'h1FFF);
   endtask

   task automatic t_upper();
      logic [31:0] d;
      wr(A_EN, 32'hFFFF_E000); rd(A_MSK, d); check("R10 upper bits ignored", d, 32'h0);
      wr(A_EN, 32'hFFFF_FFFF); rd(A_MSK, d); check("R10 mask upper zero", d, 32'h1FFF);
      rd(8'h30, d); check("R10 unmapped reads 0", d, 32'h0);
      wr(A_DIS, 32'h1FFF);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_mask();
      t_status();
      t_race();
      t_chan();
      t_upper();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule